// File: doc/BRIEF.md
# Ternary Lookup Table Host Port

This block is the host-facing front end of a small ternary lookup table. Each table entry is 64 bits wide and holds 32 ternary digits. Digit n is kept as a pair: the value sits in bit n, its complement sits in bit n+32, and a pair of two zeros means "don't care". A host with a 32-bit data path reaches an entry one half at a time. A segment select input picks the half. An address-valid qualifier tells the block whether the control bus carries an entry address or a command.

Addressed cycles read or write one half of an entry and set its validity bit. Command cycles cover four operations:
- store at the lowest empty entry;
- delete by index;
- delete the first entry that matches a key;
- compare a key against the table.

Every cycle that touches an index reports it on the active-address output. A companion RAM of per-entry data can therefore be written or cleared in the same step. When nothing qualifies, the output is all ones. A registered full flag tells the host when no empty entry is left.

Top module: `tcam_host_port`

## Requirements
- R1: After reset every entry is empty, aaOut is 0, matchHit is 0 and fullFlag is 0. The first store-at-next-free therefore lands at index 0.
- R2: A cycle is taken only when csAN or csBN is low. With both high, no entry, validity bit or output changes.
- R3: An addressed cycle (avN low) uses acBus as the entry index. segHi low selects bits 31..0 and segHi high selects bits 63..32. A write (wrN low) changes only the selected half. A read (wrN high) returns that half on dOut one clock later.
- R4: An addressed write marks the entry valid when vbInN is low and empty when vbInN is high. An addressed read returns the entry's validity on vbOutN, where low means valid.
- R5: Command 1 (avN high, acBus[2:0]=1, wrN low) writes dIn into the selected half of the lowest-index empty entry. It marks that entry valid and reports its index on aaOut.
- R6: Command 1 issued while every entry is valid changes no entry and drives all ones on aaOut.
- R7: Command 2 (acBus[2:0]=2) clears the validity bit of the entry whose index is in dIn[AW-1:0], and reports that index on aaOut.
- R8: Command 4 (acBus[2:0]=4) compares dIn as the key against all valid entries. Key bit n misses when it is 0 and entry bit n is 1, or when it is 1 and entry bit n+32 is 1. aaOut shows the lowest matching index and matchHit is 1. With no match, aaOut is all ones and matchHit is 0.
- R9: Command 3 (acBus[2:0]=3) performs the R8 search. It clears the validity of the lowest matching entry and reports its index and matchHit as in R8.
- R10: fullFlag follows the validity bits one clock late. It is 1 in the second cycle after the last empty entry is filled, and 0 in the second cycle after an entry of a full table is freed.
- R11: An addressed read or write reports its acBus index on aaOut one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| csAN | input | 1 | Active-low select A |
| csBN | input | 1 | Active-low select B |
| wrN | input | 1 | Low: data into the block; high: data out |
| avN | input | 1 | Low: acBus is an entry index; high: acBus is a command |
| segHi | input | 1 | Selects the upper 32 bits of an entry |
| acBus | input | AW | Entry index or command code |
| dIn | input | 32 | Write data, key, or delete index |
| vbInN | input | 1 | Validity to write, low means valid |
| dOut | output | 32 | Read data |
| vbOutN | output | 1 | Read validity, low means valid |
| aaOut | output | AW | Index touched by the latest cycle, all ones for none |
| matchHit | output | 1 | Result of the latest search |
| fullFlag | output | 1 | No empty entry is left |

## Verification
The hardest situation to reach is a store-at-next-free into a completely full table. Every one of the fifteen entries has to be filled, and the one-cycle lag of the full flag has to be observed on the way. The stimulus gets there in stages. It builds three prefix entries, deletes some of them by index and by match so that a hole opens at index 0, then fills that hole and issues stores until no slot is left. It then frees one entry in the middle and confirms that both the flag and the next allocation move to it.

// File: rtl/tcam_host_pkg.sv
package tcam_host_pkg;
  typedef enum logic [2:0] {
    CMD_NONE     = 3'd0,
    CMD_STORE_NF = 3'd1,
    CMD_DEL_IDX  = 3'd2,
    CMD_DEL_HIT  = 3'd3,
    CMD_SEARCH   = 3'd4
  } cmd_e;

  typedef struct packed {
    logic rdAddr;
    logic wrAddr;
    logic storeNf;
    logic delIdx;
    logic delHit;
    logic search;
  } strobe_t;
endpackage

// File: rtl/tcam_host_ctrl.sv
module tcam_host_ctrl
  import tcam_host_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          csAN,
  input  logic          csBN,
  input  logic          wrN,
  input  logic          avN,
  input  logic [AW-1:0] acBus,
  output strobe_t       stb
);
  logic sel;
  logic [2:0] cmd;

  always_comb begin
    sel = ~csAN | ~csBN;
    cmd = acBus[2:0];
    stb = '0;
    stb.rdAddr  = sel & ~avN & wrN;
    stb.wrAddr  = sel & ~avN & ~wrN;
    stb.storeNf = sel & avN & ~wrN & (cmd == CMD_STORE_NF);
    stb.delIdx  = sel & avN & (cmd == CMD_DEL_IDX);
    stb.delHit  = sel & avN & (cmd == CMD_DEL_HIT);
    stb.search  = sel & avN & (cmd == CMD_SEARCH);
  end
endmodule

// File: rtl/tcam_host_dpath.sv
module tcam_host_dpath
  import tcam_host_pkg::*;
#(
  parameter int DEPTH = 15,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       stb,
  input  logic          segHi,
  input  logic [AW-1:0] acBus,
  input  logic [31:0]   dIn,
  input  logic          vbInN,
  output logic [31:0]   dOut,
  output logic          vbOutN,
  output logic [AW-1:0] aaOut,
  output logic          matchHit,
  output logic          fullFlag
);
  localparam logic [AW-1:0] NONE = '1;

  logic [63:0]      mem [DEPTH];
  logic [DEPTH-1:0] valid;
  logic [DEPTH-1:0] hit;
  logic [AW-1:0]    nextFree;
  logic [AW-1:0]    hitIdx;
  logic             anyHit;
  logic [AW-1:0]    delKey;
  logic             addrOk;
  logic             delOk;

  // ternary search of every entry against the key on dIn
  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign hit[g] = valid[g] &
      ~|((~dIn & mem[g][31:0]) | (dIn & mem[g][63:32]));
  end

  always_comb begin
    nextFree = NONE;
    hitIdx   = NONE;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!valid[i]) nextFree = AW'(i);
      if (hit[i])    hitIdx   = AW'(i);
    end
    anyHit = |hit;
    delKey = dIn[AW-1:0];
    addrOk = int'(acBus) < DEPTH;
    delOk  = int'(delKey) < DEPTH;
  end

  // entry storage, no reset needed
  always_ff @(posedge clk) begin
    if (stb.wrAddr && addrOk) begin
      if (segHi) mem[acBus][63:32] <= dIn;
      else       mem[acBus][31:0]  <= dIn;
    end else if (stb.storeNf && nextFree != NONE) begin
      if (segHi) mem[nextFree][63:32] <= dIn;
      else       mem[nextFree][31:0]  <= dIn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      valid    <= '0;
      dOut     <= '0;
      vbOutN   <= 1'b1;
      aaOut    <= '0;
      matchHit <= 1'b0;
      fullFlag <= 1'b0;
    end else begin
      fullFlag <= &valid;
      if (stb.rdAddr && addrOk) begin
        dOut   <= segHi ? mem[acBus][63:32] : mem[acBus][31:0];
        vbOutN <= ~valid[acBus];
        aaOut  <= acBus;
      end else if (stb.wrAddr && addrOk) begin
        valid[acBus] <= ~vbInN;
        aaOut        <= acBus;
      end else if (stb.storeNf) begin
        if (nextFree != NONE) valid[nextFree] <= 1'b1;
        aaOut <= nextFree;
      end else if (stb.delIdx && delOk) begin
        valid[delKey] <= 1'b0;
        aaOut         <= delKey;
      end else if (stb.delHit) begin
        if (anyHit) valid[hitIdx] <= 1'b0;
        aaOut    <= hitIdx;
        matchHit <= anyHit;
      end else if (stb.search) begin
        aaOut    <= hitIdx;
        matchHit <= anyHit;
      end
    end
  end
endmodule

// File: rtl/tcam_host_port.sv
module tcam_host_port
  import tcam_host_pkg::*;
#(
  parameter int DEPTH = 15,
  parameter int AW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          csAN,
  input  logic          csBN,
  input  logic          wrN,
  input  logic          avN,
  input  logic          segHi,
  input  logic [AW-1:0] acBus,
  input  logic [31:0]   dIn,
  input  logic          vbInN,
  output logic [31:0]   dOut,
  output logic          vbOutN,
  output logic [AW-1:0] aaOut,
  output logic          matchHit,
  output logic          fullFlag
);
  strobe_t stb;

  tcam_host_ctrl #(.AW(AW)) u_ctrl (
    .csAN(csAN), .csBN(csBN), .wrN(wrN), .avN(avN), .acBus(acBus), .stb(stb)
  );

  tcam_host_dpath #(.DEPTH(DEPTH), .AW(AW)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .segHi(segHi), .acBus(acBus),
    .dIn(dIn), .vbInN(vbInN), .dOut(dOut), .vbOutN(vbOutN), .aaOut(aaOut),
    .matchHit(matchHit), .fullFlag(fullFlag)
  );
endmodule

// File: rtl/tcam_host_port_chk.sv
module tcam_host_port_chk #(
  parameter int DEPTH = 15,
  parameter int AW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rstN,
  input logic          csAN,
  input logic          csBN,
  input logic          wrN,
  input logic          avN,
  input logic          segHi,
  input logic [AW-1:0] acBus,
  input logic [31:0]   dIn,
  input logic          vbInN,
  input logic [31:0]   dOut,
  input logic          vbOutN,
  input logic [AW-1:0] aaOut,
  input logic          matchHit,
  input logic          fullFlag
);
  localparam logic [AW-1:0] NONE = '1;
  logic sel;
  assign sel = ~csAN | ~csBN;

  assert_reset_state_R1: assert property (@(posedge clk)
    $rose(rstN) |-> (aaOut == '0 && !fullFlag && !matchHit));

  assert_deselect_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!sel) |=> ($stable(aaOut) && $stable(dOut) && $stable(matchHit)));

  assert_full_store_R6: assert property (@(posedge clk) disable iff (!rstN)
    (sel && avN && !wrN && acBus[2:0] == 3'd1 && fullFlag) |=> (aaOut == NONE));

  assert_del_index_R7: assert property (@(posedge clk) disable iff (!rstN)
    (sel && avN && acBus[2:0] == 3'd2 && int'(dIn[AW-1:0]) < DEPTH)
      |=> (aaOut == $past(dIn[AW-1:0])));

  assert_search_flag_R8: assert property (@(posedge clk) disable iff (!rstN)
    (sel && avN && acBus[2:0] == 3'd4) |=> (matchHit == (aaOut != NONE)));

  assert_addr_report_R11: assert property (@(posedge clk) disable iff (!rstN)
    (sel && !avN && int'(acBus) < DEPTH) |=> (aaOut == $past(acBus)));
endmodule

bind tcam_host_port tcam_host_port_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (.*);

// File: tb/tcam_host_port_bench.sv
module tcam_host_port_bench;
  localparam int DEPTH = 15;
  localparam int AW = 4;
  localparam logic [AW-1:0] NONE = '1;

  typedef struct {
    logic [AW-1:0] aa;
    bit            chkD;
    logic [31:0]   d;
    bit            chkV;
    logic          vbN;
    bit            chkM;
    logic          m;
    string         req;
  } exp_t;

  logic clk = 0, rstN = 0;
  logic csAN = 1, csBN = 1, wrN = 1, avN = 0, segHi = 0, vbInN = 1;
  logic [AW-1:0] acBus = '0;
  logic [31:0] dIn = '0;
  logic [31:0] dOut;
  logic vbOutN, matchHit, fullFlag;
  logic [AW-1:0] aaOut;
  int total = 0, bad = 0;
  exp_t sb[$];

  always #4 clk = ~clk;

  tcam_host_port u_tcam_host_port (
    .clk(clk), .rstN(rstN), .csAN(csAN), .csBN(csBN), .wrN(wrN), .avN(avN),
    .segHi(segHi), .acBus(acBus), .dIn(dIn), .vbInN(vbInN), .dOut(dOut),
    .vbOutN(vbOutN), .aaOut(aaOut), .matchHit(matchHit), .fullFlag(fullFlag)
  );

  function automatic logic [31:0] loOf(logic [31:0] a, logic [31:0] m);
    return a & m;
  endfunction
  function automatic logic [31:0] hiOf(logic [31:0] a, logic [31:0] m);
    return ~a & m;
  endfunction

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // monitor: compares registered outputs at the negedge after each cycle
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      check(aaOut == e.aa, e.req, "aaOut", 32'(aaOut), 32'(e.aa));
      if (e.chkD) check(dOut == e.d, e.req, "dOut", dOut, e.d);
      if (e.chkV) check(vbOutN == e.vbN, e.req, "vbOutN", 32'(vbOutN), 32'(e.vbN));
      if (e.chkM) check(matchHit == e.m, e.req, "matchHit", 32'(matchHit), 32'(e.m));
    end
  end

  task automatic cycle(logic a, logic b, logic w, logic av, logic sh,
                       logic [AW-1:0] ac, logic [31:0] d, logic vb, exp_t e);
    @(negedge clk);
    csAN = a; csBN = b; wrN = w; avN = av; segHi = sh; acBus = ac; dIn = d; vbInN = vb;
    @(posedge clk);
    sb.push_back(e);
    @(negedge clk);
    csAN = 1; csBN = 1;
  endtask

  function automatic exp_t ex(logic [AW-1:0] aa, string req);
    exp_t e;
    e.aa = aa; e.chkD = 0; e.d = '0; e.chkV = 0; e.vbN = 1; e.chkM = 0; e.m = 0; e.req = req;
    return e;
  endfunction

  task automatic wrAddr(logic [AW-1:0] a, logic sh, logic [31:0] d, logic vb, string req);
    cycle(0, 1, 0, 0, sh, a, d, vb, ex(a, req));
  endtask
  task automatic rdAddr(logic [AW-1:0] a, logic sh, bit cd, logic [31:0] d, logic vb, string req);
    exp_t e = ex(a, req);
    e.chkD = cd; e.d = d; e.chkV = 1; e.vbN = vb;
    cycle(1, 0, 1, 0, sh, a, '0, 1, e);
  endtask
  task automatic storeNf(logic [31:0] d, logic [AW-1:0] aa, string req);
    cycle(0, 1, 0, 1, 0, AW'(1), d, 1, ex(aa, req));
  endtask
  task automatic search(logic [3:0] code, logic [31:0] key, logic [AW-1:0] aa, logic m, string req);
    exp_t e = ex(aa, req);
    e.chkM = 1; e.m = m;
    cycle(0, 0, 1, 1, 0, AW'(code), key, 1, e);
  endtask

  localparam logic [31:0] A0 = 32'hC0A80100, M0 = 32'hFFFFFF00;
  localparam logic [31:0] A1 = 32'hC0A80000, M1 = 32'hFFFF0000;
  localparam logic [31:0] A2 = 32'h0A000000, M2 = 32'hFF000000;

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    check(aaOut == '0, "R1", "aaOut", 32'(aaOut), 0);
    check(!fullFlag, "R1", "fullFlag", 32'(fullFlag), 0);
    check(!matchHit, "R1", "matchHit", 32'(matchHit), 0);

    // build prefixes: R5 store at next free, R11 addressed write reports index
    storeNf(loOf(A0, M0), 0, "R1");
    wrAddr(0, 1, hiOf(A0, M0), 0, "R11");
    storeNf(loOf(A1, M1), 1, "R5");
    wrAddr(1, 1, hiOf(A1, M1), 0, "R11");
    storeNf(loOf(A2, M2), 2, "R5");
    wrAddr(2, 1, hiOf(A2, M2), 0, "R11");

    // R3 halves, R4 validity readback
    rdAddr(0, 0, 1, loOf(A0, M0), 0, "R3");
    rdAddr(0, 1, 1, hiOf(A0, M0), 0, "R3");
    rdAddr(2, 0, 1, loOf(A2, M2), 0, "R3");

    // R8 searches
    search(4, 32'hC0A80105, 0, 1, "R8");
    search(4, 32'hC0A8FF01, 1, 1, "R8");
    search(4, 32'h0A010203, 2, 1, "R8");
    search(4, 32'h0B000000, NONE, 0, "R8");

    // R7 delete by index
    cycle(0, 1, 1, 1, 0, AW'(2), 32'd0, 1, ex(0, "R7"));
    rdAddr(0, 0, 0, '0, 1, "R7");
    search(4, 32'hC0A80105, 1, 1, "R7");

    // R9 delete by match
    search(3, 32'h0A112233, 2, 1, "R9");
    search(4, 32'h0A112233, NONE, 0, "R9");

    // R5 lowest empty is index 0 again
    storeNf(loOf(A0, M0), 0, "R5");
    wrAddr(0, 1, hiOf(A0, M0), 0, "R5");

    // R2 deselected write: no aaOut change, entry stays empty
    cycle(1, 1, 0, 0, 0, AW'(5), 32'hDEADBEEF, 0, ex(0, "R2"));
    rdAddr(5, 0, 0, '0, 1, "R2");
    // R3 high-half write leaves low half alone
    wrAddr(1, 1, 32'h12345678, 0, "R3");
    rdAddr(1, 0, 1, loOf(A1, M1), 0, "R3");
    rdAddr(1, 1, 1, 32'h12345678, 0, "R3");
    // R4 write with vbInN high marks empty
    wrAddr(3, 0, 32'h0, 1, "R4");
    rdAddr(3, 0, 1, 32'h0, 1, "R4");

    // fill indices 2..14 (R10 lag)
    for (int i = 2; i < DEPTH; i++) begin
      storeNf(32'hFFFFFFFF, AW'(i), "R5");
      if (i < DEPTH - 1) check(!fullFlag, "R10", "fullFlag early", 32'(fullFlag), 0);
    end
    check(!fullFlag, "R10", "fullFlag same cycle", 32'(fullFlag), 0);
    @(negedge clk);
    check(fullFlag, "R10", "fullFlag set", 32'(fullFlag), 1);

    // R6 store into full table
    storeNf(32'h0, NONE, "R6");
    rdAddr(7, 0, 0, '0, 0, "R6");

    // free index 7
    cycle(0, 1, 1, 1, 0, AW'(2), 32'd7, 1, ex(7, "R7"));
    check(fullFlag, "R10", "fullFlag lag", 32'(fullFlag), 1);
    @(negedge clk);
    check(!fullFlag, "R10", "fullFlag clear", 32'(fullFlag), 0);
    storeNf(32'h0, 7, "R5");

    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule